// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block caches recent virtual-to-physical page mappings for a 14-bit virtual and 12-bit physical address space with 64-byte pages. A requester presents a virtual address. One cycle later the block reports whether a cached mapping exists. On a hit it returns the physical address, built from the cached physical page number and the untouched 6-bit page offset. On a miss it returns zero, and the requester resolves the mapping elsewhere.

Storage is 16 entries: 4 sets of 4 ways. Each entry keeps a valid flag, a 6-bit tag and a 6-bit physical page number. The 8-bit virtual page number is split into two fields. Bits [1:0] pick the set. Bits [7:2] are the tag compared in every way of that set.

New mappings arrive on a refill port and are placed in the set named by their page number. The placement order is:
1. A way already holding the same tag is updated.
2. Otherwise, the lowest-numbered empty way is used.
3. Otherwise, a way chosen by that set's rotating pointer is replaced.

A flush input empties the whole buffer in one cycle.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns a miss, and rsp_valid and rsp_hit are low until the first request.
- R2: rsp_valid is high in exactly the cycle after a cycle with lk_valid high. rsp_hit is never high while rsp_valid is low.
- R3: A lookup hits when the set selected by VPN[1:0] holds a valid way whose tag equals VPN[7:2]. VPN is lk_vaddr[13:6]. On a hit, rsp_paddr[11:6] is that way's physical page number.
- R4: On a miss, rsp_hit is 0 and rsp_paddr is 0.
- R5: On a hit, rsp_paddr[5:0] equals lk_vaddr[5:0] of the request.
- R6: A refill only affects the set given by fill_vpn[1:0]. The same tag in another set still misses.
- R7: A refill whose VPN is already valid in its set overwrites that entry's page number and never creates a second copy of the tag.
- R8: A refill with no matching tag goes to the lowest-numbered invalid way of its set, and does not move that set's pointer.
- R9: A refill into a full set with no matching tag replaces the way named by that set's pointer and then advances the pointer by one, wrapping after way 3. Pointers start at way 0, are independent per set, and are kept across a flush.
- R10: When flush is high, every entry is invalid from the next cycle. A refill in the same cycle is dropped.
- R11: A lookup issued in the same cycle as a refill or flush is answered from the contents before that refill or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 14 | Virtual address to translate |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Refill request strobe |
| fill_vpn | input | 8 | Virtual page number of the new mapping |
| fill_ppn | input | 6 | Physical page number of the new mapping |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup found a mapping |
| rsp_paddr | output | 12 | Translated physical address, zero on a miss |

## Verification
The bench targets the orderings that a wrong design would get quietly wrong:
- **Same tag in two sets.** A design that ignores the set field would report a false hit.
- **Refill of a page already cached.** A design that skips the tag match would store a duplicate, and a later eviction would leave a stale page number hitting.
- **Eviction order across sets.** Filling sets past capacity, flushing, and refilling exposes two faults. A shared or reset-on-flush pointer evicts the wrong entry. A design that uses the pointer even when an empty way exists loses an entry that should survive.
- **Same-cycle lookups.** Lookups placed in the same cycle as a refill or a flush catch a design that forwards the new contents.

// File: rtl/tlb_pkg.sv
// Package tlb_pkg
// Default geometry of the translation buffer and the refill placement kinds.
// Assumes power-of-two set and way counts.
package tlb_pkg;
    localparam int TLB_VA_W  = 14;
    localparam int TLB_PA_W  = 12;
    localparam int TLB_OFF_W = 6;
    localparam int TLB_SETS  = 4;
    localparam int TLB_WAYS  = 4;

    // How a refill picks its way, in priority order
    typedef enum logic [1:0] {
        FILL_UPDATE = 2'd0,
        FILL_FREE   = 2'd1,
        FILL_EVICT  = 2'd2
    } fill_kind_e;
endpackage

// File: rtl/tlb_way_store.sv
// Module tlb_way_store
// Entry storage: valid flags (reset and flushable), tags and page numbers.
// Assumes at most one write per cycle; flush wins over a write.
module tlb_way_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_set,
    input  logic [WAY_W-1:0]                      wr_way,
    input  logic [TAG_W-1:0]                      wr_tag,
    input  logic [PPN_W-1:0]                      wr_ppn,
    output logic [SETS-1:0][WAYS-1:0]             valid_o,
    output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_o,
    output logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_o
);
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;

    // Valid flags: cleared by reset or flush, set by a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag and page number payload: written with the valid flag, never reset
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            ppn_q[wr_set][wr_way] <= wr_ppn;
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;
    assign ppn_o   = ppn_q;
endmodule

// File: rtl/tlb_set_match.sv
// Module tlb_set_match
// Compares one tag against all ways of a set and reports the matching way.
// Assumes at most one valid way per set carries a given tag.
module tlb_set_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    input  logic [TAG_W-1:0]            tag_in,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] way_eq;

    // One comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign way_eq[g] = set_valid[g] && (set_tag[g] == tag_in);
    end

    // Encode the matching way
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (way_eq[i]) hit_way = WAY_W'(i);
        end
    end

    assign hit = |way_eq;
endmodule

// File: rtl/tlb_victim.sv
// Module tlb_victim
// Picks the refill way: matching tag, else lowest free way, else the set's
// rotating pointer, which advances only on an eviction.
// Assumes WAYS is a power of two so the pointer wraps naturally.
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_set,
    input  logic [WAYS-1:0]   set_valid,
    input  logic              match_hit,
    input  logic [WAY_W-1:0]  match_way,
    output logic [WAY_W-1:0]  victim_way
);
    logic [SETS-1:0][WAY_W-1:0] ptr_q;
    logic                       has_free;
    logic [WAY_W-1:0]           free_way;
    fill_kind_e                 kind;

    // Lowest-numbered invalid way
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!set_valid[i]) begin
                has_free = 1'b1;
                free_way = WAY_W'(i);
            end
        end
    end

    // Placement decision by priority
    always_comb begin
        if (match_hit)     kind = FILL_UPDATE;
        else if (has_free) kind = FILL_FREE;
        else               kind = FILL_EVICT;
    end

    // Way chosen for this decision
    always_comb begin
        case (kind)
            FILL_UPDATE: victim_way = match_way;
            FILL_FREE:   victim_way = free_way;
            default:     victim_way = ptr_q[fill_set];
        endcase
    end

    // Per-set pointer: advances after each eviction in that set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en && kind == FILL_EVICT) begin
            ptr_q[fill_set] <= ptr_q[fill_set] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_lookup.sv
// Module tlb_lookup
// Top level: set-associative page translation buffer with a registered
// lookup result, a refill port and a whole-buffer flush.
// Assumes the offset passes through untouched and page numbers fit PA_W-OFF_W.
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int VA_W  = TLB_VA_W,
    parameter int PA_W  = TLB_PA_W,
    parameter int OFF_W = TLB_OFF_W,
    parameter int SETS  = TLB_SETS,
    parameter int WAYS  = TLB_WAYS,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr
);
    logic [SETS-1:0][WAYS-1:0]             st_valid;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  st_tag;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  st_ppn;

    logic [IDX_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic             lk_hit, fl_hit, fill_do;
    logic [WAY_W-1:0] lk_way, fl_way, victim_way;

    assign lk_set  = lk_vaddr[OFF_W +: IDX_W];
    assign lk_tag  = lk_vaddr[VA_W-1 -: TAG_W];
    assign fl_set  = fill_vpn[IDX_W-1:0];
    assign fl_tag  = fill_vpn[VPN_W-1 -: TAG_W];
    assign fill_do = fill_valid && !flush;

    tlb_way_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_do), .wr_set(fl_set), .wr_way(victim_way),
        .wr_tag(fl_tag), .wr_ppn(fill_ppn),
        .valid_o(st_valid), .tag_o(st_tag), .ppn_o(st_ppn)
    );

    tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .set_valid(st_valid[lk_set]), .set_tag(st_tag[lk_set]),
        .tag_in(lk_tag), .hit(lk_hit), .hit_way(lk_way)
    );

    tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .set_valid(st_valid[fl_set]), .set_tag(st_tag[fl_set]),
        .tag_in(fl_tag), .hit(fl_hit), .hit_way(fl_way)
    );

    tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_do), .fill_set(fl_set),
        .set_valid(st_valid[fl_set]), .match_hit(fl_hit), .match_way(fl_way),
        .victim_way(victim_way)
    );

    // Response register: result from contents before this cycle's updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_paddr <= (lk_valid && lk_hit)
                       ? {st_ppn[lk_set][lk_way], lk_vaddr[OFF_W-1:0]}
                       : '0;
        end
    end
endmodule

// File: rtl/tlb_lookup_chk.sv
// Module tlb_lookup_chk
// Property checker for tlb_lookup, attached with bind below.
module tlb_lookup_chk #(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  lk_valid,
    input logic [VA_W-1:0]                       lk_vaddr,
    input logic                                  flush,
    input logic                                  rsp_valid,
    input logic                                  rsp_hit,
    input logic [PA_W-1:0]                       rsp_paddr,
    input logic [SETS-1:0][WAYS-1:0]             st_valid,
    input logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  st_tag
);
    logic dup_tag;

    // Any set holding the same tag in two valid ways
    always_comb begin
        dup_tag = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int a = 0; a < WAYS; a++)
                for (int b = a + 1; b < WAYS; b++)
                    if (st_valid[s][a] && st_valid[s][b] && st_tag[s][a] == st_tag[s][b])
                        dup_tag = 1'b1;
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rsp_valid && !rsp_hit));
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);
    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));
    assert_no_dup_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_tag);
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_valid == '0));
endmodule

bind tlb_lookup tlb_lookup_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .st_valid(st_valid), .st_tag(st_tag)
);

// File: tb/tb_tlb_lookup.sv
`timescale 1ns/1ps
module tb_tlb_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [13:0] lk_vaddr = '0;
    logic        flush = 1'b0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_vpn = '0;
    logic [5:0]  fill_ppn = '0;
    logic        rsp_valid, rsp_hit;
    logic [11:0] rsp_paddr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model of the buffer
    bit       mv[4][4];
    bit [5:0] mt[4][4];
    bit [5:0] mp[4][4];
    int       mptr[4];

    // Scoreboard: expected {hit, paddr} and requirement tag per lookup
    logic [12:0] exp_q[$];
    string       req_q[$];

    always #10 clk = ~clk;

    tlb_lookup dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .flush(flush), .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr)
    );

    function automatic logic [12:0] model_lookup(input logic [13:0] va);
        int s = int'(va[7:6]);
        logic [12:0] r = '0;
        for (int w = 0; w < 4; w++)
            if (mv[s][w] && mt[s][w] == va[13:8]) r = {1'b1, mp[s][w], va[5:0]};
        return r;
    endfunction

    function automatic void model_fill(input logic [7:0] vpn, input logic [5:0] ppn);
        int s = int'(vpn[1:0]);
        int way = -1;
        for (int w = 0; w < 4; w++)
            if (way < 0 && mv[s][w] && mt[s][w] == vpn[7:2]) way = w;
        for (int w = 0; w < 4; w++)
            if (way < 0 && !mv[s][w]) way = w;
        if (way < 0) begin
            way = mptr[s];
            mptr[s] = (mptr[s] + 1) % 4;
        end
        mv[s][way] = 1'b1;
        mt[s][way] = vpn[7:2];
        mp[s][way] = ppn;
    endfunction

    // Driver: one cycle of stimulus; records expectation before model update
    task automatic step(input bit lv, input logic [13:0] va, input bit fv,
                        input logic [7:0] fvpn, input logic [5:0] fppn,
                        input bit fl, input string req);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
        if (lv) begin
            exp_q.push_back(model_lookup(va));
            req_q.push_back(req);
        end
        if (fl) begin
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
        end else if (fv) begin
            model_fill(fvpn, fppn);
        end
    endtask

    task automatic look(input logic [13:0] va, input string req);
        step(1'b1, va, 1'b0, '0, '0, 1'b0, req);
    endtask

    task automatic fill(input logic [7:0] vpn, input logic [5:0] ppn);
        step(1'b0, '0, 1'b1, vpn, ppn, 1'b0, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, '0, 1'b0, "");
    endtask

    // Monitor: compares each response with the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL R2: response without request, actual hit=%0b paddr=%h expected none",
                             rsp_hit, rsp_paddr);
                end else begin
                    logic [12:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if ({rsp_hit, rsp_paddr} !== e) begin
                        n_fails++;
                        $display("FAIL %s: actual hit=%0b paddr=%h expected hit=%0b paddr=%h",
                                 r, rsp_hit, rsp_paddr, e[12], e[11:0]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R2: watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            mptr[s] = 0;
            for (int w = 0; w < 4; w++) begin mv[s][w] = 1'b0; mt[s][w] = '0; mp[s][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: actual valid=%0b hit=%0b expected 0 0", rsp_valid, rsp_hit);
        end
        look(14'h03D4, "R1");
        look(14'h3FFF, "R1");

        // R3/R5: basic hit with offset pass-through
        fill(8'h0F, 6'h0D);
        look(14'h03D4, "R3");
        look(14'h03C0, "R5");
        look(14'h03FF, "R5");
        // R4/R6: same tag in set 0 misses
        look(14'h0314, "R6");
        look(14'h0354, "R4");

        // R11: lookup in the same cycle as a refill to the same set
        step(1'b1, 14'h0305, 1'b1, 8'h0C, 6'h21, 1'b0, "R11");
        look(14'h0305, "R6");

        // R7: refill of a cached page updates in place
        fill(8'h0F, 6'h22);
        look(14'h03D4, "R7");
        // R8: fill remaining ways of set 3, then R9: evictions rotate
        fill(8'h07, 6'h01);
        fill(8'h0B, 6'h02);
        fill(8'h17, 6'h03);
        fill(8'h1F, 6'h04);          // evicts way 0 (tag of 0x0F)
        look(14'h03D4, "R9");
        look(14'h01C0, "R8");
        look(14'h07C1, "R9");
        fill(8'h23, 6'h05);          // evicts way 1 (0x07)
        look(14'h01C0, "R9");
        look(14'h02C2, "R9");
        look(14'h08C3, "R9");

        // R9: set 1 pointer independent of set 3
        fill(8'h01, 6'h11);
        fill(8'h05, 6'h12);
        fill(8'h09, 6'h13);
        fill(8'h0D, 6'h14);
        fill(8'h11, 6'h15);          // evicts way 0 of set 1
        look(14'h0040, "R9");
        look(14'h0150, "R9");
        look(14'h0460, "R9");

        // R10/R11: flush with refill and lookup in the same cycle
        step(1'b1, 14'h02C2, 1'b1, 8'h02, 6'h3F, 1'b1, "R11");
        look(14'h02C2, "R10");
        look(14'h0080, "R10");
        look(14'h0305, "R10");

        // R8/R9: after flush, free ways fill first, then pointer (kept at 2) evicts way 2
        fill(8'h03, 6'h31);
        fill(8'h07, 6'h32);
        fill(8'h0B, 6'h33);
        fill(8'h0F, 6'h34);
        look(14'h00C7, "R8");
        look(14'h03C8, "R8");
        fill(8'h13, 6'h35);          // evicts way 2 (0x0B)
        look(14'h02C9, "R9");
        look(14'h00CA, "R9");
        look(14'h04CB, "R9");

        // R2: back-to-back requests, then an idle gap
        for (int i = 0; i < 6; i++) look(14'((i * 14'h0251) ^ 14'h00C3), "R3");
        idle(4);

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R2: actual %0d responses missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule